// File: doc/BRIEF.md
# Serial TDM Output Timing with Programmable Advance

This block turns a stream of parallel channel bytes into one bit-serial TDM output. It runs on a 131.072 MHz system clock and follows a frame pulse. The pulse marks the boundary between the last channel of one frame and channel 0 of the next. Each byte goes out most significant bit first.

Two line rates are available. In the slow rate each bit lasts 8 system clocks and a 16384-clock frame holds 256 channels. In the fast rate each bit lasts 4 system clocks and the same frame holds 512 channels. A 2-bit code moves every output bit boundary earlier by a whole number of system clocks. The step per code is 2 clocks at the slow rate and 1 clock at the fast rate.

The block requests bytes through a fetch strobe and a channel index. It expects the matching byte on its data input in the same cycle. The byte is loaded at the advanced channel boundary. Rate and advance settings take effect only at a frame pulse.

Top module: `tdm_out_advance`

## Requirements
- R1: While reset is asserted, `serOut` is 0, `fetchStrobe` is 0 and `fetchChan` is 0.
- R2: With `rateSel`=0 and `advSel`=0, bit 7 of channel 0 appears on `serOut` in the clock after the one in which `framePulse` is high. Each following bit lasts 8 clocks, bits go 7 down to 0, and channels follow in ascending order.
- R3: With `rateSel`=1 each bit lasts 4 clocks. A frame of `FRAME_CLKS` clocks then carries `FRAME_CLKS`/32 channels.
- R4: With `rateSel`=0, `advSel` code k (0..3) makes every bit and channel boundary occur 2k clocks earlier than with code 0.
- R5: With `rateSel`=1, `advSel` code k makes every boundary occur k clocks earlier than with code 0.
- R6: `rateSel` and `advSel` are sampled only in a cycle where `framePulse` is high. A change at any other time leaves `serOut` unchanged until the next frame pulse.
- R7: `fetchStrobe` is high in the cycle before the advanced start of each channel. In that cycle `fetchChan` holds that channel's index, and `chanByte` is loaded for output from the next clock.
- R8: Without further frame pulses the output keeps running: after the last channel of a frame, channel 0 follows with the same timing.
- R9: A frame pulse that arrives mid-frame restarts the output at channel 0 with the newly sampled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| framePulse | input | 1 | One-cycle frame boundary marker |
| rateSel | input | 1 | 0 = 8 clocks per bit, 1 = 4 clocks per bit |
| advSel | input | 2 | Advance code, step set by the rate |
| chanByte | input | WORD_W | Byte for the channel named by `fetchChan` |
| fetchStrobe | output | 1 | Byte is taken this cycle |
| fetchChan | output | CHAN_W | Index of the channel being fetched |
| serOut | output | 1 | Serial data output |

## Verification
The bench builds the block with `FRAME_CLKS`=256, which gives 4 channels per frame at the slow rate and 8 at the fast rate. This covers every advance code at both rates, frame wrap-around without pulses, and settings changed mid-frame, all within a few thousand clocks. The bench predicts each serial bit from the frame phase and compares it on every clock. It also checks each fetch index.

// File: rtl/tdm_adv_pkg.sv
`timescale 1ns/1ps
package tdm_adv_pkg;
  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } serStrobe_t;

  localparam int SLOW_BIT_LOG2 = 3;  // 8 clocks per bit
  localparam int FAST_BIT_LOG2 = 2;  // 4 clocks per bit

  // advance in system clocks for a rate and a code
  function automatic logic [2:0] advClocks(rate_e r, logic [1:0] code);
    if (r == RATE_SLOW) return {code, 1'b0};
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/tdm_adv_ctrl.sv
`timescale 1ns/1ps
module tdm_adv_ctrl
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_CLKS = 16384,
  parameter int WORD_W     = 8,
  localparam int PH_W      = $clog2(FRAME_CLKS),
  localparam int WORD_LOG2 = $clog2(WORD_W),
  localparam int CHAN_W    = PH_W - WORD_LOG2 - FAST_BIT_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic              rateSel,
  input  logic [1:0]        advSel,
  output serStrobe_t        strb,
  output logic [CHAN_W-1:0] fetchChan
);
  localparam int SH_SLOW = SLOW_BIT_LOG2 + WORD_LOG2;
  localparam int SH_FAST = FAST_BIT_LOG2 + WORD_LOG2;

  logic [PH_W-1:0] advPhase, advPhaseNext;
  logic [PH_W-1:0] bitMask, chanMask;
  rate_e activeRate, nextRate, reqRate;
  logic chanStart, bitStart;

  assign reqRate  = rate_e'(rateSel);
  assign nextRate = framePulse ? reqRate : activeRate;

  always_comb begin
    if (framePulse)
      advPhaseNext = PH_W'(advClocks(reqRate, advSel));
    else if (advPhase == PH_W'(FRAME_CLKS - 1))
      advPhaseNext = '0;
    else
      advPhaseNext = advPhase + 1'b1;
  end

  always_comb begin
    if (nextRate == RATE_SLOW) begin
      bitMask   = PH_W'((1 << SLOW_BIT_LOG2) - 1);
      chanMask  = PH_W'((1 << SH_SLOW) - 1);
      fetchChan = CHAN_W'(advPhaseNext >> SH_SLOW);
    end else begin
      bitMask   = PH_W'((1 << FAST_BIT_LOG2) - 1);
      chanMask  = PH_W'((1 << SH_FAST) - 1);
      fetchChan = CHAN_W'(advPhaseNext >> SH_FAST);
    end
  end

  assign chanStart  = (advPhaseNext & chanMask) == '0;
  assign bitStart   = (advPhaseNext & bitMask) == '0;
  assign strb.load  = framePulse | chanStart;
  assign strb.shift = bitStart & ~strb.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advPhase   <= '0;
      activeRate <= RATE_SLOW;
    end else begin
      advPhase <= advPhaseNext;
      if (framePulse) activeRate <= reqRate;
    end
  end
endmodule

// File: rtl/tdm_adv_dp.sv
`timescale 1ns/1ps
module tdm_adv_dp
  import tdm_adv_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  input  logic [WORD_W-1:0] chanByte,
  output logic              serOut
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.load)  shiftReg <= chanByte;
    else if (strb.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign serOut = shiftReg[WORD_W-1];
endmodule

// File: rtl/tdm_out_advance.sv
`timescale 1ns/1ps
module tdm_out_advance
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_CLKS = 16384,
  parameter int WORD_W     = 8,
  localparam int CHAN_W    = $clog2(FRAME_CLKS) - $clog2(WORD_W) - FAST_BIT_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic              rateSel,
  input  logic [1:0]        advSel,
  input  logic [WORD_W-1:0] chanByte,
  output logic              fetchStrobe,
  output logic [CHAN_W-1:0] fetchChan,
  output logic              serOut
);
  serStrobe_t strb;

  tdm_adv_ctrl #(.FRAME_CLKS(FRAME_CLKS), .WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rateSel(rateSel),
    .advSel(advSel), .strb(strb), .fetchChan(fetchChan)
  );

  tdm_adv_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .chanByte(chanByte), .serOut(serOut)
  );

  assign fetchStrobe = strb.load;
endmodule

// File: rtl/tdm_out_advance_chk.sv
`timescale 1ns/1ps
module tdm_out_advance_chk
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_CLKS = 16384,
  parameter int WORD_W     = 8,
  parameter int CHAN_W     = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              framePulse,
  input logic [WORD_W-1:0] chanByte,
  input logic              fetchStrobe,
  input logic [CHAN_W-1:0] fetchChan,
  input logic              serOut,
  input serStrobe_t        strb
);
  logic [3:0]        gap;
  logic [CHAN_W-1:0] lastChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap      <= '0;
      lastChan <= '0;
    end else begin
      gap <= (strb.load | strb.shift) ? 4'd0 : gap + 4'd1;
      if (fetchStrobe) lastChan <= fetchChan;
    end
  end

  // R7: the fetched byte's MSB is driven in the next clock
  assert_load_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchStrobe |=> serOut == $past(chanByte[WORD_W-1]));

  // R2: output holds between bit boundaries
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shift) |=> $stable(serOut));

  // R2: no bit lasts longer than 8 clocks
  assert_bit_span_R2: assert property (@(posedge clk) disable iff (!rstN)
    gap < 4'd8);

  // R9: a frame pulse fetches channel 0
  assert_pulse_chan0_R9: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> fetchStrobe && fetchChan == '0);

  // R8: channel order between pulses is ascending with wrap to 0
  assert_chan_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStrobe && !framePulse) |->
      (fetchChan == CHAN_W'(lastChan + 1'b1) || fetchChan == '0));
endmodule

bind tdm_out_advance tdm_out_advance_chk #(
  .FRAME_CLKS(FRAME_CLKS), .WORD_W(WORD_W), .CHAN_W(CHAN_W)
) chk_i (
  .clk(clk), .rstN(rstN), .framePulse(framePulse), .chanByte(chanByte),
  .fetchStrobe(fetchStrobe), .fetchChan(fetchChan), .serOut(serOut), .strb(strb)
);

// File: tb/tdm_out_advance_tb.sv
`timescale 1ns/1ps
module tdm_out_advance_tb_top;
  localparam int F      = 256;
  localparam int WORD_W = 8;
  localparam int CHAN_W = $clog2(F) - 3 - 2;

  // {rateSel, advSel, expected advance in clocks}
  localparam logic [5:0] VEC [8] = '{
    {1'b0, 2'd0, 3'd0}, {1'b0, 2'd1, 3'd2}, {1'b0, 2'd2, 3'd4}, {1'b0, 2'd3, 3'd6},
    {1'b1, 2'd0, 3'd0}, {1'b1, 2'd1, 3'd1}, {1'b1, 2'd2, 3'd2}, {1'b1, 2'd3, 3'd3}
  };

  logic clk = 0;
  logic rstN, framePulse, rateSel;
  logic [1:0] advSel;
  logic [WORD_W-1:0] chanByte;
  logic fetchStrobe, serOut;
  logic [CHAN_W-1:0] fetchChan;

  int nChecks = 0, nFail = 0;
  string curTag = "R2";
  bit mValid = 0, mFast = 0, pendFast = 0;
  int mPh = 0, pendAdv = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] byteOf(int ch);
    return 8'(ch * 53 + 167);
  endfunction

  assign chanByte = byteOf(int'(fetchChan));

  tdm_out_advance #(.FRAME_CLKS(F), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rateSel(rateSel),
    .advSel(advSel), .chanByte(chanByte), .fetchStrobe(fetchStrobe),
    .fetchChan(fetchChan), .serOut(serOut)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected frame phase, advanced
  always @(posedge clk) begin
    if (!rstN) mValid <= 0;
    else if (framePulse) begin
      mValid <= 1; mFast <= pendFast; mPh <= pendAdv;
    end else mPh <= (mPh + 1) % F;
  end

  always @(negedge clk) begin
    if (rstN && mValid) begin
      int bitLen, chanLen, ch, b, nx;
      bit expBit;
      logic [7:0] bv;
      bitLen  = mFast ? 4 : 8;
      chanLen = bitLen * 8;
      ch = mPh / chanLen;
      b  = 7 - (mPh % chanLen) / bitLen;
      bv = byteOf(ch);
      expBit = bv[b];
      chk(serOut == expBit, curTag, int'(serOut), int'(expBit));
      if (fetchStrobe && !framePulse) begin
        nx = (mPh + 1) % F;
        chk(nx % chanLen == 0, "R7 strobe position", nx % chanLen, 0);
        chk(int'(fetchChan) == nx / chanLen, "R7 fetch index", int'(fetchChan), nx / chanLen);
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    @(posedge clk); #1 framePulse = 1;
    @(posedge clk); #1 framePulse = 0;
  endtask

  task automatic setCfg(int i);
    rateSel  = VEC[i][5];
    advSel   = VEC[i][4:3];
    pendFast = VEC[i][5];
    pendAdv  = int'(VEC[i][2:0]);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN = 0; framePulse = 0; rateSel = 0; advSel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(serOut == 1'b0, "R1 serOut", int'(serOut), 0);
    chk(fetchStrobe == 1'b0, "R1 fetchStrobe", int'(fetchStrobe), 0);
    chk(fetchChan == '0, "R1 fetchChan", int'(fetchChan), 0);
    @(posedge clk); #1 rstN = 1;

    // table walk: each setting, then a mid-frame change that must wait
    for (int i = 0; i < 8; i++) begin
      setCfg(i);
      if (VEC[i][5] == 1'b0) curTag = (VEC[i][4:3] == 2'd0) ? "R2" : "R4";
      else                   curTag = (VEC[i][4:3] == 2'd0) ? "R3" : "R5";
      pulse();
      waitCyc(F / 2);
      curTag = "R6";
      setCfg((i + 3) % 8);
      waitCyc(F / 2 - 1);
      setCfg(i);
    end

    // free running over several frame wraps
    setCfg(6);
    curTag = "R8";
    pulse();
    waitCyc(3 * F);
    setCfg(3);
    pulse();
    waitCyc(2 * F);

    // resynchronisation mid-frame
    curTag = "R9";
    setCfg(5);
    waitCyc(F / 3);
    pulse();
    waitCyc(F / 2 + 7);
    setCfg(2);
    pulse();
    waitCyc(37);
    setCfg(7);
    pulse();
    waitCyc(F);

    finishRun();
  end
endmodule